// File: doc/BRIEF.md
# SRAM Sleep Mode Controller

This block sits between the access path of a synchronous SRAM and its array, and manages the low-power sleep state. An external request pin can be raised or lowered at any time without regard to the clock. The controller passes it through a chain of flip-flops first. It then steps through four phases: awake, entering, asleep and exiting. The phase sets a sleep-active flag, an output-disable for the data bus, and a gate that decides whether a new access may reach the array.

Entry and exit each last a fixed number of clock cycles. The exit phase also covers the recovery window. During that window chip selects are still ignored, so no read or write can disturb the stored contents. An access accepted in the last awake cycle normally completes one cycle later. If sleep entry begins in that cycle instead, the access is reported as invalid.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: After reset, sleep_active=0, dq_hiz=0, gate_open=1, and acc_done=acc_invalid=0.
- R2: The request passes through two clock stages before it acts. A level change first sampled at rising edge k can change the phase no earlier than edge k+2.
- R3: Entry takes two cycles. With the request held high, sleep_active rises at edge k+4, where k is the first edge that samples the request high.
- R4: dq_hiz is 1 and gate_open is 0 in every cycle in which the phase is not awake. This covers entering, asleep and exiting.
- R5: arr_en equals acc_valid while gate_open is 1, and is 0 otherwise. arr_we equals arr_en AND acc_write.
- R6: An access with arr_en=1 at edge t is reported in the cycle after edge t. If the phase after t is awake, acc_done=1. Otherwise acc_invalid=1. The two flags are never 1 together.
- R7: Exit and recovery take two cycles in total. With the request held low, gate_open rises at edge k+4, where k is the first edge that samples the request low. Accesses offered before that edge are ignored.
- R8: If the request drops while the phase is entering, entry still completes. sleep_active is then 1 for exactly one cycle, and the exit sequence follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| acc_valid | input | 1 | Access requested this cycle (chip selected) |
| acc_write | input | 1 | Requested access is a write |
| arr_en | output | 1 | Access forwarded to the array |
| arr_we | output | 1 | Forwarded access is a write |
| acc_done | output | 1 | Access from the previous cycle completed |
| acc_invalid | output | 1 | Access from the previous cycle dropped by sleep entry |
| sleep_active | output | 1 | Array is in sleep |
| dq_hiz | output | 1 | Data bus drivers disabled |
| gate_open | output | 1 | New accesses are accepted |

## Verification
Several properties are checked on every cycle. No array access may occur while the bus is disabled. An invalid flag must trace back to an access accepted the cycle before. Completion and drop may never coincide. The gate must stay shut in the cycle sleep_active falls. The exact entry and exit latencies, and how a request pulse that collapses during entry is handled, are shown only by the bench scenarios. There, a cycle model follows long sleep periods, short request pulses and continuous traffic.

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl #(
  parameter int SYNC_STAGES    = 2,
  parameter int ENTRY_CYCLES   = 2,
  parameter int EXIT_CYCLES    = 2,
  parameter int RECOVER_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic acc_valid,
  input  logic acc_write,
  output logic arr_en,
  output logic arr_we,
  output logic acc_done,
  output logic acc_invalid,
  output logic sleep_active,
  output logic dq_hiz,
  output logic gate_open
);

  localparam int WAKE_CYCLES = (EXIT_CYCLES > RECOVER_CYCLES) ? EXIT_CYCLES : RECOVER_CYCLES;
  localparam int MAX_CYCLES  = (ENTRY_CYCLES > WAKE_CYCLES) ? ENTRY_CYCLES : WAKE_CYCLES;
  localparam int CW          = $clog2(MAX_CYCLES + 1);

  typedef enum logic [1:0] {ST_AWAKE, ST_ENTER, ST_SLEEP, ST_EXIT} phase_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s;
  phase_t                 phase;
  logic [CW-1:0]          left_q;
  logic                   pend_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};

  assign req_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= ST_AWAKE;
      left_q <= '0;
    end else begin
      unique case (phase)
        ST_AWAKE: if (req_s) begin
          phase  <= ST_ENTER;
          left_q <= CW'(ENTRY_CYCLES - 1);
        end
        ST_ENTER: if (left_q == '0) phase <= ST_SLEEP;
                  else left_q <= left_q - 1'b1;
        ST_SLEEP: if (!req_s) begin
          phase  <= ST_EXIT;
          left_q <= CW'(WAKE_CYCLES - 1);
        end
        ST_EXIT:  if (left_q == '0) phase <= ST_AWAKE;
                  else left_q <= left_q - 1'b1;
        default:  phase <= ST_AWAKE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= arr_en;

  assign gate_open    = (phase == ST_AWAKE);
  assign dq_hiz       = (phase != ST_AWAKE);
  assign sleep_active = (phase == ST_SLEEP);
  assign arr_en       = acc_valid & gate_open;
  assign arr_we       = arr_en & acc_write;
  assign acc_done     = pend_q & gate_open;
  assign acc_invalid  = pend_q & ~gate_open;

  // R4 R5
  no_access_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en |-> !dq_hiz);

  // R6
  invalid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_invalid |-> $past(arr_en));

  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_done && acc_invalid));

  // R7
  recover_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_active) |-> !gate_open);

  // R3
  sleep_after_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(dq_hiz));

endmodule

// File: tb/sram_sleep_ctrl_bench.sv
module sram_sleep_ctrl_bench;
  logic clk = 0, rst_n = 0, sleep_req = 0, acc_valid = 0, acc_write = 0;
  logic arr_en, arr_we, acc_done, acc_invalid, sleep_active, dq_hiz, gate_open;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_sleep_ctrl u_sram_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .acc_valid(acc_valid),
    .acc_write(acc_write), .arr_en(arr_en), .arr_we(arr_we), .acc_done(acc_done),
    .acc_invalid(acc_invalid), .sleep_active(sleep_active), .dq_hiz(dq_hiz),
    .gate_open(gate_open));

  // reference: 0 awake, 1 entering, 2 asleep, 3 exiting
  int m_s1 = 0, m_s2 = 0, m_ph = 0, m_age = 0, m_pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ph = 0; m_age = 0; m_pend = 0;
    end else begin
      m_pend = (acc_valid && m_ph == 0) ? 1 : 0;
      case (m_ph)
        0: if (m_s2 != 0) begin m_ph = 1; m_age = 0; end
        1: begin m_age++; if (m_age == 2) m_ph = 2; end
        2: if (m_s2 == 0) begin m_ph = 3; m_age = 0; end
        default: begin m_age++; if (m_age == 2) m_ph = 0; end
      endcase
      m_s2 = m_s1;
      m_s1 = sleep_req ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int e_en;
    e_en = (acc_valid && m_ph == 0) ? 1 : 0;
    chk(sleep_active == (m_ph == 2), "R3", "sleep_active", sleep_active, m_ph == 2);
    chk(dq_hiz == (m_ph != 0), "R4", "dq_hiz", dq_hiz, m_ph != 0);
    chk(gate_open == (m_ph == 0), "R7", "gate_open", gate_open, m_ph == 0);
    chk(arr_en == e_en, "R5", "arr_en", arr_en, e_en);
    chk(arr_we == (e_en && acc_write), "R5", "arr_we", arr_we, e_en && acc_write);
    chk(acc_done == (m_pend && m_ph == 0), "R6", "acc_done", acc_done, m_pend && m_ph == 0);
    chk(acc_invalid == (m_pend && m_ph != 0), "R6", "acc_invalid", acc_invalid, m_pend && m_ph != 0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    compare();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    chk(0, "WATCHDOG", "timeout", 1, 0);
    summary();
  end

  initial begin
    int seen;
    int hi_cnt;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(sleep_active == 0 && dq_hiz == 0 && gate_open == 1 && acc_done == 0 && acc_invalid == 0,
        "R1", "reset outputs", {sleep_active, dq_hiz, gate_open, acc_done, acc_invalid}, 5'b00100);
    @(negedge clk); rst_n = 1;
    // awake traffic
    for (int i = 0; i < 12; i++) begin
      acc_valid = (i % 3) != 2; acc_write = i[0];
      tick();
    end
    // R2 R3 entry latency with access on every cycle
    acc_valid = 1; sleep_req = 1;
    seen = 0;
    for (int i = 1; i <= 8; i++) begin
      acc_write = i[1];
      tick();
      if (seen == 0 && sleep_active) seen = i;
      if (i == 2) chk(gate_open == 1, "R2", "gate still open after two edges", gate_open, 1);
    end
    chk(seen == 5, "R3", "entry latency in edges", seen, 5);
    // asleep: accesses ignored
    for (int i = 0; i < 10; i++) begin
      acc_valid = 1; acc_write = 1; tick();
      chk(arr_en == 0, "R5", "access while asleep", arr_en, 0);
    end
    // R7 exit and recovery latency
    sleep_req = 0; seen = 0;
    for (int i = 1; i <= 8; i++) begin
      tick();
      if (seen == 0 && gate_open) seen = i;
    end
    chk(seen == 5, "R7", "wake latency in edges", seen, 5);
    // R8 short pulse dropping during entry
    acc_valid = 0;
    repeat (3) tick();
    sleep_req = 1; tick(); sleep_req = 0;
    hi_cnt = 0;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (sleep_active) hi_cnt++;
    end
    chk(hi_cnt == 1, "R8", "sleep_active cycles for short pulse", hi_cnt, 1);
    chk(gate_open == 1, "R8", "awake after short pulse", gate_open, 1);
    // mixed pseudo-random traffic and requests
    for (int i = 0; i < 400; i++) begin
      acc_valid = ((i * 7) % 5) < 3;
      acc_write = ((i * 13) % 3) == 0;
      if ((i % 37) == 0) sleep_req = ~sleep_req;
      if ((i % 53) == 5) sleep_req = 1;
      if ((i % 53) == 7) sleep_req = 0;
      tick();
    end
    // reset while asleep
    sleep_req = 1; repeat (8) tick();
    rst_n = 0; sleep_req = 0; acc_valid = 0;
    @(negedge clk); #1;
    chk(gate_open == 1 && dq_hiz == 0 && sleep_active == 0, "R1", "reset from sleep",
        {sleep_active, dq_hiz, gate_open}, 3'b001);
    summary();
  end
endmodule